// File: doc/BRIEF.md
# Multi-precision integer matrix multiply-accumulate

The block computes D = A × B + C on 4×4 matrices in a single issue. Sixty-four multiply lanes form every element product A[i][k]·B[k][j] at once, and sixteen adder trees each reduce four products into a 32-bit accumulator element seeded with C[i][j]. A 2-bit mode picks the operand precision: signed 8-bit integers, signed 4-bit integers, or single-bit binary operands. In binary mode each dot-product term is the XOR of the two bits, so the sum over the inner dimension is a population count.

Operands enter packed, together with the mode, through a valid/ready handshake. The result leaves packed with an output valid and is held until the downstream side takes it. The pipeline has two register stages: products, then accumulated sums. Back-pressure on the output stalls both stages together and loses no data.

Top module: `mma_int_unit`

## Requirements
- R1: With mode 2'b00, each A and B element is an 8-bit two's-complement value. A element [r][c] sits at bits [8*(4r+c) +: 8] of a_i, and B is packed the same way in b_i. Each output is D[i][j] = C[i][j] + Σk A[i][k]·B[k][j]. C and D element [r][c] sit at bits [32*(4r+c) +: 32].
- R2: With mode 2'b01, elements are 4-bit two's-complement values at bits [4*(4r+c) +: 4], and D is formed as in R1.
- R3: With mode 2'b10, elements are single bits at bit 4r+c, and D[i][j] = C[i][j] + popcount over k of (A[i][k] XOR B[k][j]).
- R4: With mode 2'b11, D equals C.
- R5: Accumulation wraps modulo 2^32.
- R6: With out_ready_i high, out_valid_o is low on the cycle after acceptance and high with the result two cycles after acceptance.
- R7: in_ready_o is low only while out_valid_o is high and out_ready_i is low.
- R8: While out_valid_o is high and out_ready_i is low, d_o and out_valid_o hold. Every accepted operation is later delivered in order.
- R9: Operand bits of a_i and b_i above the width used by the selected mode have no effect on D.
- R10: After reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid |
| in_ready_o | output | 1 | Unit can accept operands |
| mode_i | input | 2 | Operand precision select |
| a_i | input | 128 | Packed A matrix |
| b_i | input | 128 | Packed B matrix |
| c_i | input | 512 | Packed C matrix, 32-bit elements |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts result |
| d_o | output | 512 | Packed D matrix, 32-bit elements |

## Verification
Two events can fall in the same cycle: a held result is consumed downstream while a new operand set is accepted, and the second-stage result moves forward at the same time. The bench provokes this by filling both stages with out_ready_i low and then raising out_ready_i while a third operation waits at the input. It then checks that the three results come out in order with their expected values, and that d_o holds and in_ready_o stays low for the whole stall.

// File: rtl/mma_pkg.sv
package mma_pkg;
  typedef enum logic [1:0] {
    MODE_I8  = 2'b00,
    MODE_I4  = 2'b01,
    MODE_BIN = 2'b10,
    MODE_RSV = 2'b11
  } mma_mode_e;
endpackage

// File: rtl/mma_mul_lane.sv
module mma_mul_lane
  import mma_pkg::*;
#(
  parameter int EW = 8,
  localparam int HW = EW / 2,
  localparam int PW = 2 * EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  mma_mode_e     mode_i,
  input  logic [EW-1:0] a_full_i,
  input  logic [EW-1:0] b_full_i,
  input  logic [HW-1:0] a_half_i,
  input  logic [HW-1:0] b_half_i,
  input  logic          a_bit_i,
  input  logic          b_bit_i,
  output logic [PW-1:0] prod_o
);
  logic signed [PW-1:0] ax, bx, p_d;
  logic [PW-1:0] prod_q;

  always_comb begin
    ax  = '0;
    bx  = '0;
    p_d = '0;
    unique case (mode_i)
      MODE_I8: begin
        ax  = {{(PW-EW){a_full_i[EW-1]}}, a_full_i};
        bx  = {{(PW-EW){b_full_i[EW-1]}}, b_full_i};
        p_d = ax * bx;
      end
      MODE_I4: begin
        ax  = {{(PW-HW){a_half_i[HW-1]}}, a_half_i};
        bx  = {{(PW-HW){b_half_i[HW-1]}}, b_half_i};
        p_d = ax * bx;
      end
      MODE_BIN: p_d = {{(PW-1){1'b0}}, a_bit_i ^ b_bit_i};
      default:  p_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   prod_q <= '0;
    else if (en_i) prod_q <= p_d;

  assign prod_o = prod_q;

  // R3: binary term is a single XOR bit
  a_r3_bin_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == MODE_BIN |=> prod_o <= PW'(1));
  // R2: 4-bit signed products stay within [-56, 64]
  a_r2_i4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == MODE_I4 |=> ($signed(prod_o) <= 64) && ($signed(prod_o) >= -56));
endmodule

// File: rtl/mma_dot_acc.sv
module mma_dot_acc
  import mma_pkg::*;
#(
  parameter int DIM = 4,
  parameter int PW  = 16,
  parameter int AW  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  mma_mode_e         mode_i,
  input  logic [DIM*PW-1:0] prod_i,
  input  logic [AW-1:0]     c_i,
  output logic [AW-1:0]     d_o
);
  logic [AW-1:0] sum_d, d_q;
  logic [PW-1:0] term;

  always_comb begin
    sum_d = c_i;
    term  = '0;
    for (int k = 0; k < DIM; k++) begin
      term  = prod_i[k*PW +: PW];
      sum_d = sum_d + {{(AW-PW){term[PW-1]}}, term};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   d_q <= '0;
    else if (en_i) d_q <= sum_d;

  assign d_o = d_q;

  // R4: reserved mode passes C through
  a_r4_reserved_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == MODE_RSV |=> d_o == $past(c_i));
  // R3: binary popcount adds at most DIM
  a_r3_popcount_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == MODE_BIN |=> (d_o - $past(c_i)) <= AW'(DIM));
endmodule

// File: rtl/mma_int_unit.sv
module mma_int_unit
  import mma_pkg::*;
#(
  parameter int DIM = 4,
  parameter int EW  = 8,
  parameter int AW  = 32,
  localparam int HW    = EW / 2,
  localparam int PW    = 2 * EW,
  localparam int NEL   = DIM * DIM,
  localparam int NLANE = NEL * DIM,
  localparam int OPW   = NEL * EW,
  localparam int ACW   = NEL * AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [1:0]     mode_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic [ACW-1:0] c_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [ACW-1:0] d_o
);
  mma_mode_e mode_in, mode1_q;
  logic v1_q, v2_q, adv;
  logic [ACW-1:0] c1_q;
  logic [NLANE*PW-1:0] prod_w;

  assign mode_in    = mma_mode_e'(mode_i);
  assign adv        = !v2_q || out_ready_i;  // whole pipe moves together
  assign in_ready_o = adv;
  assign out_valid_o = v2_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      mode1_q <= MODE_RSV;
      c1_q    <= '0;
    end else if (adv) begin
      v1_q    <= in_valid_i;
      v2_q    <= v1_q;
      mode1_q <= mode_in;
      c1_q    <= c_i;
    end

  for (genvar gi = 0; gi < DIM; gi++) begin : g_row
    for (genvar gj = 0; gj < DIM; gj++) begin : g_col
      localparam int E = gi * DIM + gj;
      for (genvar gk = 0; gk < DIM; gk++) begin : g_k
        localparam int IA = gi * DIM + gk;
        localparam int IB = gk * DIM + gj;
        localparam int L  = E * DIM + gk;
        mma_mul_lane #(.EW(EW)) u_lane (
          .clk_i    (clk_i),
          .rst_ni   (rst_ni),
          .en_i     (adv),
          .mode_i   (mode_in),
          .a_full_i (a_i[IA*EW +: EW]),
          .b_full_i (b_i[IB*EW +: EW]),
          .a_half_i (a_i[IA*HW +: HW]),
          .b_half_i (b_i[IB*HW +: HW]),
          .a_bit_i  (a_i[IA]),
          .b_bit_i  (b_i[IB]),
          .prod_o   (prod_w[L*PW +: PW])
        );
      end
      mma_dot_acc #(.DIM(DIM), .PW(PW), .AW(AW)) u_acc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (adv && v1_q),
        .mode_i (mode1_q),
        .prod_i (prod_w[E*DIM*PW +: DIM*PW]),
        .c_i    (c1_q[E*AW +: AW]),
        .d_o    (d_o[E*AW +: AW])
      );
    end
  end

  // R8: stalled result holds
  a_r8_hold_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(d_o));
  // R7: free output stage never blocks input
  a_r7_ready_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
  // R6: accepted operation reaches stage one, then the output
  a_r6_stage_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> v1_q);
  a_r6_stage_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q && in_ready_o |=> out_valid_o);
endmodule

// File: tb/mma_int_unit_tb.sv
`timescale 1ns/1ps
module mma_int_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [127:0] a = '0, b = '0;
  logic [511:0] c = '0, d;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mma_int_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .mode_i(mode), .a_i(a), .b_i(b), .c_i(c),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .d_o(d)
  );

  function automatic logic [511:0] model(logic [1:0] m, logic [127:0] aa,
                                         logic [127:0] bb, logic [511:0] cc);
    logic [511:0] r;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        logic [31:0] acc;
        acc = cc[32*(4*i+j) +: 32];
        for (int k = 0; k < 4; k++) begin
          int ia, ib, x, y;
          ia = 4*i + k;
          ib = 4*k + j;
          case (m)
            2'b00: begin x = $signed(aa[8*ia +: 8]); y = $signed(bb[8*ib +: 8]); acc = acc + 32'(x*y); end
            2'b01: begin x = $signed(aa[4*ia +: 4]); y = $signed(bb[4*ib +: 4]); acc = acc + 32'(x*y); end
            2'b10: acc = acc + 32'(aa[ia] ^ bb[ib]);
            default: ;
          endcase
        end
        r[32*(4*i+j) +: 32] = acc;
      end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // single op with free output; checks latency and result
  task automatic run_op(logic [1:0] m, logic [127:0] aa, logic [127:0] bb,
                        logic [511:0] cc, string req, output logic [511:0] got);
    @(negedge clk);
    mode = m; a = aa; b = bb; c = cc; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 early valid", 512'(out_valid), 512'(0));
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid at two", 512'(out_valid), 512'(1));
    chk(d == model(m, aa, bb, cc), req, d, model(m, aa, bb, cc));
    got = d;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R10 out_valid", 512'(out_valid), 512'(0));
    chk(in_ready == 1'b1, "R10 in_ready", 512'(in_ready), 512'(1));
  endtask

  task automatic t_int8();
    logic [511:0] g;
    run_op(2'b00, rnd128(), rnd128(), rnd512(), "R1 int8 random", g);
    run_op(2'b00, {16{8'h80}}, {16{8'h80}}, '0, "R1 int8 min*min", g);
    run_op(2'b00, {16{8'h7f}}, {16{8'h80}}, {16{32'd5}}, "R1 int8 max*min", g);
  endtask

  task automatic t_int4();
    logic [511:0] g;
    run_op(2'b01, {64'h0, rnd128() >> 64}, {64'h0, rnd128() >> 64}, rnd512(), "R2 int4 random", g);
    run_op(2'b01, {64'h0, {16{4'h8}}}, {64'h0, {16{4'h7}}}, '0, "R2 int4 min*max", g);
  endtask

  task automatic t_bin();
    logic [511:0] g;
    run_op(2'b10, {112'h0, 16'hA5C3}, {112'h0, 16'h3C96}, rnd512(), "R3 binary mixed", g);
    run_op(2'b10, {112'h0, 16'hFFFF}, 128'h0, {16{32'd100}}, "R3 binary all ones", g);
  endtask

  task automatic t_reserved();
    logic [511:0] cc, g;
    cc = rnd512();
    run_op(2'b11, rnd128(), rnd128(), cc, "R4 reserved passes C", g);
    chk(g == cc, "R4 reserved equals C", g, cc);
  endtask

  task automatic t_wrap();
    logic [511:0] g;
    run_op(2'b00, {16{8'h7f}}, {16{8'h7f}}, {16{32'h7fff_ffff}}, "R5 wrap positive", g);
    chk(g[31:0] == 32'h8000_fc03, "R5 wrap element 0", 512'(g[31:0]), 512'(32'h8000_fc03));
  endtask

  task automatic t_upper();
    logic [127:0] al, bl;
    logic [511:0] cc, g0, g1;
    al = {64'h0, rnd128() >> 64};
    bl = {64'h0, rnd128() >> 64};
    cc = rnd512();
    run_op(2'b01, al, bl, cc, "R9 int4 clean", g0);
    run_op(2'b01, al | {rnd128() >> 64, 64'h0}, bl | {rnd128() >> 64, 64'h0}, cc, "R9 int4 dirty", g1);
    chk(g0 == g1, "R9 int4 upper ignored", g1, g0);
    run_op(2'b10, {112'h0, 16'h1234}, {112'h0, 16'h8765}, cc, "R9 bin clean", g0);
    run_op(2'b10, {rnd128() >> 16, 16'h1234}, {rnd128() >> 16, 16'h8765}, cc, "R9 bin dirty", g1);
    chk(g0 == g1, "R9 bin upper ignored", g1, g0);
  endtask

  task automatic t_backpressure();
    logic [127:0] a1, a2, a3, b1, b2, b3;
    logic [511:0] c1, c2, c3, e1, e2, e3;
    a1 = rnd128(); a2 = rnd128(); a3 = rnd128();
    b1 = rnd128(); b2 = rnd128(); b3 = rnd128();
    c1 = rnd512(); c2 = rnd512(); c3 = rnd512();
    e1 = model(2'b00, a1, b1, c1);
    e2 = model(2'b01, a2, b2, c2);
    e3 = model(2'b10, a3, b3, c3);
    @(negedge clk);
    out_ready = 1'b0;
    mode = 2'b00; a = a1; b = b1; c = c1; in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready with empty output", 512'(in_ready), 512'(1));
    mode = 2'b01; a = a2; b = b2; c = c2;
    @(negedge clk);
    chk(out_valid && d == e1, "R8 first result", d, e1);
    chk(in_ready == 1'b0, "R7 ready low on stall", 512'(in_ready), 512'(0));
    mode = 2'b10; a = a3; b = b3; c = c3;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(out_valid && d == e1, "R8 held during stall", d, e1);
      chk(in_ready == 1'b0, "R7 ready held low", 512'(in_ready), 512'(0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && d == e2, "R8 second result after release", d, e2);
    @(negedge clk);
    chk(out_valid && d == e3, "R8 third result in order", d, e3);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 pipe drained", 512'(out_valid), 512'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_int8();
    t_int4();
    t_bin();
    t_reserved();
    t_wrap();
    t_upper();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule